// File: doc/BRIEF.md
# Iterative Shift-Add Multiplier

The block multiplies two 32-bit operands into a 64-bit result, one multiplier bit per cycle. A single 32-bit multiplicand register and a 64-bit product register hold the data. The low half of the product register is first loaded with the multiplier. On each step the block looks at the product's least significant bit and adds the multiplicand into the product's upper half when that bit is set. It then shifts the 33-bit sum, with the rest of the product, right by one place. The bits of the multiplier leave the register at the same rate as the bits of the product enter it.

A caller pulses `start` with both operands and a mode bit. In signed mode the operands are reduced to magnitudes before the iterations begin. If the operand signs differ, one extra cycle negates the full 64-bit result. The result is always complete, so no overflow is flagged. It appears on two 32-bit halves and stays there until the next accepted start.

Top module: `iter_mult`

## Requirements
- R1: While reset is held and right after its release, `busy` and `done` are 0 and `prodHi`/`prodLo` are both 0.
- R2: A `start` sampled high while `busy` is 0 begins an operation, and `busy` is 1 from the next cycle.
- R3: `done` is high for exactly one cycle, with `busy` already 0. It comes WIDTH+1 busy cycles after the start was accepted (WIDTH steps plus one sign-fix cycle). In bench terms, it is seen 34 clock edges after the cycle in which `start` was driven.
- R4: With `isSigned` = 0, `{prodHi,prodLo}` at `done` equals the unsigned 64-bit product of `opA` and `opB`.
- R5: With `isSigned` = 1, `{prodHi,prodLo}` at `done` equals the two's-complement 64-bit product of the operands taken as signed numbers.
- R6: Operands and mode are captured only when a start is accepted. A `start` pulse while `busy` is 1 is ignored, and so are operand or mode changes. The result delivered is that of the accepted operands.
- R7: Between operations, `{prodHi,prodLo}` holds the last result until the next accepted start.
- R8: Corner operands give the full 64-bit product without loss: zero, all ones unsigned, the most negative value times itself signed (0x4000000000000000), and the most negative value times the most positive value.
- R9: A start may be accepted in the same cycle that `done` is high. The back-to-back operation produces its own correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| isSigned | input | 1 | 1 = signed operands, 0 = unsigned |
| opA | input | 32 | Multiplicand operand |
| opB | input | 32 | Multiplier operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result valid |
| prodHi | output | 32 | Upper half of the product |
| prodLo | output | 32 | Lower half of the product |

## Verification
The hardest case to reach from the ports is an operation disturbed while it runs. The operand buses and the mode bit change, and extra start pulses arrive during the iterations, while the original result must still come out intact. The stimulus drives such noise on several cycles in the middle of an operation and pushes no expectation for it. The scoreboard therefore fails if any disturbance leaks into a result. Back-to-back starts are issued in the same cycle as `done`, which covers the turnaround from the sign-fix cycle to a fresh load.

// File: rtl/iter_mult_pkg.sv
package iter_mult_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture operands, clear upper product
    logic step;   // one test/add/shift iteration
    logic fix;    // apply sign correction to the result
  } mulStrobe_t;
endpackage

// File: rtl/iter_mult_ctrl.sv
module iter_mult_ctrl
  import iter_mult_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output mulStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  localparam int CW = $clog2(WIDTH);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX} state_t;
  state_t state;
  logic [CW-1:0] stepCnt;

  always_comb begin
    strobe.load = (state == S_IDLE) && start;
    strobe.step = (state == S_RUN);
    strobe.fix  = (state == S_FIX);
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          state   <= S_RUN;
          stepCnt <= '0;
        end
        S_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == CW'(WIDTH - 1)) state <= S_FIX;
        end
        S_FIX: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iter_mult_dpath.sv
module iter_mult_dpath
  import iter_mult_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mulStrobe_t       strobe,
  input  logic             isSigned,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] prodHi,
  output logic [WIDTH-1:0] prodLo
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand;
  logic [PW-1:0]    prod;
  logic             negRes;

  logic [WIDTH-1:0] magA, magB;
  logic [WIDTH:0]   upperSum;

  // magnitudes in signed mode, raw values otherwise
  always_comb begin
    magA = (isSigned && opA[WIDTH-1]) ? (~opA + 1'b1) : opA;
    magB = (isSigned && opB[WIDTH-1]) ? (~opB + 1'b1) : opB;
  end

  // 33-bit add into the upper half, gated by the live multiplier bit
  assign upperSum = {1'b0, prod[PW-1:WIDTH]} + (prod[0] ? {1'b0, mcand} : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcand  <= '0;
      prod   <= '0;
      negRes <= 1'b0;
    end else if (strobe.load) begin
      mcand  <= magA;
      prod   <= {{WIDTH{1'b0}}, magB};
      negRes <= isSigned && (opA[WIDTH-1] ^ opB[WIDTH-1]);
    end else if (strobe.step) begin
      prod <= {upperSum, prod[WIDTH-1:1]};
    end else if (strobe.fix && negRes) begin
      prod <= ~prod + 1'b1;
    end
  end

  assign prodHi = prod[PW-1:WIDTH];
  assign prodLo = prod[WIDTH-1:0];
endmodule

// File: rtl/iter_mult.sv
module iter_mult
  import iter_mult_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             isSigned,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] prodHi,
  output logic [WIDTH-1:0] prodLo
);
  mulStrobe_t strobe;

  iter_mult_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .strobe(strobe), .busy(busy), .done(done)
  );

  iter_mult_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .isSigned(isSigned),
    .opA(opA), .opB(opB), .prodHi(prodHi), .prodLo(prodLo)
  );
endmodule

// File: rtl/iter_mult_chk.sv
module iter_mult_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] prodHi,
  input logic [WIDTH-1:0] prodLo
);
  localparam int RW = $clog2(WIDTH + 2) + 1;

  logic [RW-1:0] busyRun;
  logic          lastBusy;

  // length of the latest busy stretch, held after it ends
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyRun  <= '0;
      lastBusy <= 1'b0;
    end else begin
      lastBusy <= busy;
      if (busy) busyRun <= lastBusy ? busyRun + 1'b1 : RW'(1);
    end
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busyRun == RW'(WIDTH + 1)));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable({prodHi, prodLo}));
endmodule

bind iter_mult iter_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .prodHi(prodHi), .prodLo(prodLo)
);

// File: tb/tb_iter_mult.sv
module tb_iter_mult;
  localparam int W = 32;
  localparam int LAT = 34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic isSigned = 1'b0;
  logic [W-1:0] opA = '0, opB = '0;
  logic busy, done;
  logic [W-1:0] prodHi, prodLo;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic [63:0] lastExp = '0;

  typedef struct {
    logic [63:0] exp;
    int          issued;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  iter_mult #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .isSigned(isSigned),
    .opA(opA), .opB(opB), .busy(busy), .done(done),
    .prodHi(prodHi), .prodLo(prodLo)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] refMul(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
    logic [63:0] ea, eb;
    ea = s ? {{32{a[31]}}, a} : {32'b0, a};
    eb = s ? {{32{b[31]}}, b} : {32'b0, b};
    return ea * eb;
  endfunction

  // driver: waits for idle, pulses start, pushes expectation
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input logic s, input string tag);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    opA = a; opB = b; isSigned = s; start = 1'b1;
    it.exp = refMul(a, b, s);
    it.issued = cyc;
    it.tag = tag;
    sbq.push_back(it);
    lastExp = it.exp;
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor: compares results as done appears
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R3 unexpected done", {prodHi, prodLo}, 64'h0);
      end else begin
        item_t it;
        it = sbq.pop_front();
        check({prodHi, prodLo} === it.exp, it.tag, {prodHi, prodLo}, it.exp);
        check(cyc - it.issued == LAT, "R3 latency", 64'(cyc - it.issued), 64'(LAT));
        check(busy == 1'b0, "R3 busy low at done", {63'b0, busy}, 64'h0);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] x, y;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && {prodHi, prodLo} == 0, "R1 in reset",
          {prodHi, prodLo}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && {prodHi, prodLo} == 0, "R1 after reset",
          {prodHi, prodLo}, 64'h0);

    // R2: busy rises right after accept
    issue(32'd3, 32'd5, 1'b0, "R4 small unsigned");
    check(busy == 1'b1, "R2 busy after start", {63'b0, busy}, 64'h1);

    issue(32'h0, 32'hDEAD_BEEF, 1'b0, "R8 zero operand");
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R8 all ones unsigned");
    issue(32'h8000_0000, 32'd2, 1'b0, "R4 msb unsigned");
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R5 minus one squared");
    issue(32'hFFFF_FFF9, 32'd9, 1'b1, "R5 negative times positive");
    issue(32'd12345, 32'hFFFF_0000, 1'b1, "R5 positive times negative");
    issue(32'h8000_0000, 32'h8000_0000, 1'b1, "R8 most negative squared");
    issue(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R8 min times max");

    // R6: disturb operands, mode and start while busy
    issue(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, "R6 disturbed operation");
    repeat (5) @(negedge clk);
    opA = 32'hFFFF_FFFF; opB = 32'h7; isSigned = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    opA = 32'h1; opB = 32'h1; isSigned = 1'b0; start = 1'b1;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;

    // pseudo-random mixed patterns, back-to-back (R9)
    x = 32'h1357_9BDF; y = 32'h2468_ACE0;
    for (int i = 0; i < 12; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      y = y ^ (y << 7);  y = y ^ (y >> 9);  y = y ^ (y << 8);
      issue(x, y, i[0], i[0] ? "R9 back-to-back signed" : "R9 back-to-back unsigned");
    end

    // wait for everything, then R7 hold
    while (busy || sbq.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    check({prodHi, prodLo} === lastExp, "R7 result held", {prodHi, prodLo}, lastExp);
    check(sbq.size() == 0, "R3 all results delivered", 64'(sbq.size()), 64'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule